// File: doc/BRIEF.md
# Register-Backed Operand Stack

This block is a last-in first-out operand stack for an expression-evaluating datapath. The two most recent entries sit in two on-chip registers, a top register and a second register, so that pushes, pops and two-operand arithmetic run without touching memory while the stack is shallow. Anything deeper lives in a window of word-addressed memory. A pointer tracks the most recently spilled word. A lower-bound register and an upper-bound register fence the window.

A caller first issues a setup command that loads the window bounds and empties the stack. It then streams push, pop and arithmetic commands. When a push finds both registers occupied, the second register is written out to memory before the new value lands. When a pop or an arithmetic command leaves the second register empty and memory still holds words, the block reads one word back. During either access the block raises busy and ignores commands. Overflow and underflow are reported as one-cycle fault pulses, and the faulting command leaves every piece of state untouched.

Top module: `opstk_top`

## Requirements
- R1: A push (cmd_kind 1) into a stack holding fewer than two entries completes with no memory access. The pushed value appears on tos_data, tos_valid is high, and the previous top becomes the second entry.
- R2: A push that finds both registers occupied writes the second entry to memory (mem_we high) at address pointer+1, with the pointer then equal to that address. Afterwards the old top is second and the pushed value is on top, so spilled words fill base+1, base+2, ... upward.
- R3: A push that finds both registers occupied while the pointer equals the upper bound makes no memory request and changes no state. It raises fault_ovf for exactly the one cycle following acceptance. The capacity is therefore upper−lower+2 entries.
- R4: A pop (cmd_kind 2) removes the top entry, and the second entry becomes the top. If memory then holds words, the block reads the word at the pointer into the second register and decrements the pointer, so values return in last-in first-out order across spills.
- R5: An arithmetic command (cmd_kind 3) replaces the top two entries with one result on top, reducing the depth by one, with a refill as in R4. cmd_op selects the operation: 0 is add, 1 is subtract (second minus top), 2 is bitwise AND and 3 is bitwise OR. Results wrap modulo 2^DW.
- R6: A pop on an empty stack, or an arithmetic command with fewer than two entries, changes no state. It raises fault_unf for exactly the one cycle following acceptance.
- R7: A memory request keeps mem_addr, mem_we and mem_wdata stable until mem_ready is seen. busy is high from the cycle after a command that needs memory until the transfer completes, and a command presented while busy is ignored.
- R8: A setup command (cmd_kind 0) loads the lower bound from cfg_base and the upper bound from cfg_limit, sets the pointer to the lower bound and empties the stack, whatever it held.
- R9: depth always equals the number of entries held, counting both registers and the spilled words, and tos_valid is high exactly when depth is non-zero.
- R10: After reset the stack is empty, busy, both fault outputs and mem_req_valid are low, and both bounds are zero, which gives a capacity of two entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle, taken when busy is low |
| cmd_kind | input | 2 | 0 setup, 1 push, 2 pop, 3 arithmetic |
| cmd_op | input | 2 | Arithmetic select: 0 add, 1 subtract, 2 AND, 3 OR |
| cmd_data | input | DW | Value for a push |
| cfg_base | input | AW | Lower bound of the memory window, taken on setup |
| cfg_limit | input | AW | Upper bound of the memory window, taken on setup |
| busy | output | 1 | Spill or refill in progress, commands ignored |
| tos_valid | output | 1 | Stack not empty |
| tos_data | output | DW | Current top entry |
| depth | output | AW+1 | Number of entries held |
| fault_ovf | output | 1 | One-cycle overflow pulse |
| fault_unf | output | 1 | One-cycle underflow pulse |
| mem_req_valid | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write (spill) |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | DW | Data for a spill |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid in the cycle mem_ready is high |

## Verification
A reference stack kept as a queue in the bench is compared with tos_valid, tos_data and depth on every idle cycle. The stimulus comes in several patterns, and each one separates a different failure. Filling the stack past two entries and then draining it with arithmetic and pops shows whether spilled words come back in the right order and whether operands are taken in the right order, since subtraction gives a different answer when they are swapped. Pushing into a full window and popping or operating on an empty or single-entry stack shows whether a faulting command leaves the state intact. Running memory with zero and with several wait cycles, and presenting a command in the middle of a spill, shows whether the handshake holds its request and whether busy really blocks intake. A setup on a populated stack and a minimal window of capacity two finish the pattern set.

// File: rtl/opstk_pkg.sv
package opstk_pkg;

    typedef enum logic [1:0] {
        K_SETUP = 2'd0,
        K_PUSH  = 2'd1,
        K_POP   = 2'd2,
        K_ALU   = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SPILL = 2'd1,
        PH_FILL  = 2'd2
    } phase_e;

endpackage

// File: rtl/opstk_alu.sv
module opstk_alu
    import opstk_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] lhs,   // second entry
    input  logic [DW-1:0] rhs,   // top entry
    output logic [DW-1:0] res
);
    always_comb begin
        unique case (op)
            OP_ADD:  res = lhs + rhs;
            OP_SUB:  res = lhs - rhs;
            OP_AND:  res = lhs & rhs;
            OP_OR:   res = lhs | rhs;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/opstk_bounds.sv
module opstk_bounds #(
    parameter int AW      = 8,
    parameter int DEPTH_W = AW + 1
) (
    input  logic [AW-1:0]      sp,
    input  logic [AW-1:0]      base,
    input  logic [AW-1:0]      limit,
    input  logic               top_v,
    input  logic               sec_v,
    output logic [AW-1:0]      spill_addr,
    output logic [AW-1:0]      fill_next,
    output logic               region_full,
    output logic               region_empty,
    output logic [DEPTH_W-1:0] depth
);
    // Next free word lies one above the pointer; a refill reads at the pointer.
    assign spill_addr   = sp + AW'(1);
    assign fill_next    = sp - AW'(1);
    assign region_full  = (sp >= limit);
    assign region_empty = (sp == base);
    assign depth        = DEPTH_W'(sp - base) + DEPTH_W'(top_v) + DEPTH_W'(sec_v);
endmodule

// File: rtl/opstk_top.sv
module opstk_top
    import opstk_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_kind,
    input  logic [1:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_limit,
    output logic          busy,
    output logic          tos_valid,
    output logic [DW-1:0] tos_data,
    output logic [AW:0]   depth,
    output logic          fault_ovf,
    output logic          fault_unf,
    output logic          mem_req_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata
);
    localparam int DEPTH_W = AW + 1;

    typedef struct packed {
        phase_e        phase;
        logic [DW-1:0] top;
        logic [DW-1:0] sec;
        logic [DW-1:0] pend;
        logic          top_v;
        logic          sec_v;
        logic [AW-1:0] sp;
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
        logic          ovf;
        logic          unf;
    } st_t;

    st_t st_q, st_d;

    logic [DW-1:0]      alu_res;
    logic [AW-1:0]      spill_addr;
    logic [AW-1:0]      fill_next;
    logic               region_full;
    logic               region_empty;
    logic [DEPTH_W-1:0] depth_w;
    logic               xfer;
    logic [AW-1:0]      base_w;
    logic [AW-1:0]      limit_w;

    opstk_alu #(.DW(DW)) u_alu (
        .op  (alu_op_e'(cmd_op)),
        .lhs (st_q.sec),
        .rhs (st_q.top),
        .res (alu_res)
    );

    opstk_bounds #(.AW(AW), .DEPTH_W(DEPTH_W)) u_bounds (
        .sp           (st_q.sp),
        .base         (st_q.base),
        .limit        (st_q.limit),
        .top_v        (st_q.top_v),
        .sec_v        (st_q.sec_v),
        .spill_addr   (spill_addr),
        .fill_next    (fill_next),
        .region_full  (region_full),
        .region_empty (region_empty),
        .depth        (depth_w)
    );

    assign xfer = mem_req_valid && mem_ready;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_kind)
                        K_SETUP: begin
                            st_d.base  = cfg_base;
                            st_d.limit = cfg_limit;
                            st_d.sp    = cfg_base;
                            st_d.top_v = 1'b0;
                            st_d.sec_v = 1'b0;
                        end
                        K_PUSH: begin
                            if (!st_q.top_v) begin
                                st_d.top   = cmd_data;
                                st_d.top_v = 1'b1;
                            end else if (!st_q.sec_v) begin
                                st_d.sec   = st_q.top;
                                st_d.sec_v = 1'b1;
                                st_d.top   = cmd_data;
                            end else if (region_full) begin
                                st_d.ovf = 1'b1;
                            end else begin
                                st_d.pend  = cmd_data;
                                st_d.phase = PH_SPILL;
                            end
                        end
                        K_POP: begin
                            if (!st_q.top_v) begin
                                st_d.unf = 1'b1;
                            end else begin
                                st_d.top   = st_q.sec;
                                st_d.top_v = st_q.sec_v;
                                st_d.sec_v = 1'b0;
                                if (!region_empty) st_d.phase = PH_FILL;
                            end
                        end
                        K_ALU: begin
                            if (!st_q.sec_v) begin
                                st_d.unf = 1'b1;
                            end else begin
                                st_d.top   = alu_res;
                                st_d.sec_v = 1'b0;
                                if (!region_empty) st_d.phase = PH_FILL;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            PH_SPILL: begin
                if (xfer) begin
                    st_d.sp    = spill_addr;
                    st_d.sec   = st_q.top;
                    st_d.top   = st_q.pend;
                    st_d.phase = PH_IDLE;
                end
            end
            PH_FILL: begin
                if (xfer) begin
                    st_d.sec   = mem_rdata;
                    st_d.sec_v = 1'b1;
                    st_d.sp    = fill_next;
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy          = (st_q.phase != PH_IDLE);
    assign tos_valid     = st_q.top_v;
    assign tos_data      = st_q.top;
    assign depth         = depth_w;
    assign fault_ovf     = st_q.ovf;
    assign fault_unf     = st_q.unf;
    assign mem_req_valid = (st_q.phase != PH_IDLE);
    assign mem_we        = (st_q.phase == PH_SPILL);
    assign mem_addr      = (st_q.phase == PH_SPILL) ? spill_addr : st_q.sp;
    assign mem_wdata     = st_q.sec;
    assign base_w        = st_q.base;
    assign limit_w       = st_q.limit;

endmodule

// File: rtl/opstk_checker.sv
module opstk_checker #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          tos_valid,
    input logic [DW-1:0] tos_data,
    input logic [AW:0]   depth,
    input logic          fault_ovf,
    input logic          fault_unf,
    input logic          mem_req_valid,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready,
    input logic [AW-1:0] base_w,
    input logic [AW-1:0] limit_w
);
    // R2: spills stay strictly above the lower bound and never beyond the upper one
    a_r2_spill_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_we) |-> ((mem_addr > base_w) && (mem_addr <= limit_w)));

    // R7: a pending request keeps its fields until accepted
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: nothing visible moves while waiting on memory
    a_r7_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(mem_req_valid && mem_ready)) |=> ($stable(depth) && $stable(tos_data)));

    // R3: a refused push launches no memory traffic
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fault_ovf |-> !mem_req_valid);

    // R3, R6: faults are never reported together
    a_r6_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_ovf && fault_unf));

    // R6: an underflow leaves the depth as it was
    a_r6_unf_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
        fault_unf |-> $stable(depth));

    // R9: an empty top means an empty stack
    a_r9_empty_depth: assert property (@(posedge clk) disable iff (!rst_n)
        !tos_valid |-> (depth == '0));

endmodule

bind opstk_top opstk_checker #(.DW(DW), .AW(AW)) u_opstk_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .tos_valid     (tos_valid),
    .tos_data      (tos_data),
    .depth         (depth),
    .fault_ovf     (fault_ovf),
    .fault_unf     (fault_unf),
    .mem_req_valid (mem_req_valid),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ready     (mem_ready),
    .base_w        (base_w),
    .limit_w       (limit_w)
);

// File: tb/opstk_top_bench.sv
`timescale 1ns/1ps
module opstk_top_bench;
    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_kind = '0;
    logic [1:0]    cmd_op = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_limit = '0;
    logic          busy, tos_valid, fault_ovf, fault_unf;
    logic [DW-1:0] tos_data;
    logic [AW:0]   depth;
    logic          mem_req_valid, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ready = 1'b0;
    logic [DW-1:0] mem_rdata;

    always #4 clk = ~clk;

    opstk_top #(.DW(DW), .AW(AW)) u_opstk_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .busy(busy), .tos_valid(tos_valid), .tos_data(tos_data), .depth(depth),
        .fault_ovf(fault_ovf), .fault_unf(fault_unf), .mem_req_valid(mem_req_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory environment
    logic [DW-1:0] mem [0:(1<<AW)-1];
    int lat = 0;
    int wait_cnt = 0;
    int exp_wr = -1;
    int exp_rd = -1;
    assign mem_rdata = mem[mem_addr];

    initial for (int i = 0; i < (1 << AW); i++) mem[i] = '0;

    always @(negedge clk) begin
        if (mem_req_valid) begin
            if (wait_cnt >= lat) mem_ready = 1'b1;
            else begin
                mem_ready = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_ready = 1'b0;
            wait_cnt = 0;
        end
        if (mem_req_valid && mem_ready) begin
            if (mem_we) begin
                check(mem_addr == AW'(exp_wr), "R2 spill address", mem_addr, exp_wr);
                mem[mem_addr] = mem_wdata;
            end else begin
                check(mem_addr == AW'(exp_rd), "R4 refill address", mem_addr, exp_rd);
            end
        end
    end

    // Reference model
    logic [DW-1:0] ref_q [$];
    int bas = 0;
    int lim = 0;

    function automatic logic [DW-1:0] calc(input logic [1:0] op, input logic [DW-1:0] b,
                                           input logic [DW-1:0] a);
        case (op)
            2'd0: return b + a;
            2'd1: return b - a;
            2'd2: return b & a;
            default: return b | a;
        endcase
    endfunction

    // Per-clock comparison whenever the block is idle (R1, R9)
    always @(negedge clk) begin
        if (rst_n && !busy) begin
            check(tos_valid == (ref_q.size() > 0), "R9 tos_valid", tos_valid, ref_q.size() > 0);
            check(depth == (AW+1)'(ref_q.size()), "R9 depth", depth, ref_q.size());
            if (ref_q.size() > 0)
                check(tos_data == ref_q[0], "R1 tos_data", tos_data, ref_q[0]);
        end
    end

    task automatic issue(input logic [1:0] k, input logic [1:0] op, input logic [DW-1:0] d,
                         input string req);
        bit eo = 0;
        bit eu = 0;
        bit em = 0;
        int s;
        int cap;
        logic [DW-1:0] a, b;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_kind  = k;
        cmd_op    = op;
        cmd_data  = d;
        @(posedge clk);
        s   = ref_q.size();
        cap = lim - bas + 2;
        case (k)
            2'd0: begin
                ref_q.delete();
                bas = int'(cfg_base);
                lim = int'(cfg_limit);
            end
            2'd1: begin
                if (s >= cap) eo = 1;
                else begin
                    if (s >= 2) begin
                        em = 1;
                        exp_wr = bas + s - 1;
                    end
                    ref_q.push_front(d);
                end
            end
            2'd2: begin
                if (s == 0) eu = 1;
                else begin
                    void'(ref_q.pop_front());
                    if (s >= 3) begin
                        em = 1;
                        exp_rd = bas + s - 2;
                    end
                end
            end
            default: begin
                if (s < 2) eu = 1;
                else begin
                    a = ref_q.pop_front();
                    b = ref_q.pop_front();
                    ref_q.push_front(calc(op, b, a));
                    if (s >= 3) begin
                        em = 1;
                        exp_rd = bas + s - 2;
                    end
                end
            end
        endcase
        #1 cmd_valid = 1'b0;
        @(negedge clk);
        check(fault_ovf == eo, {req, " R3 fault_ovf"}, fault_ovf, eo);
        check(fault_unf == eu, {req, " R6 fault_unf"}, fault_unf, eu);
        if (em) check(busy == 1'b1, {req, " R7 busy during access"}, busy, 1);
    endtask

    task automatic push(input logic [DW-1:0] d, input string req);
        issue(2'd1, 2'd0, d, req);
    endtask

    task automatic pop(input string req);
        issue(2'd2, 2'd0, '0, req);
    endtask

    task automatic alu(input logic [1:0] op, input string req);
        issue(2'd3, op, '0, req);
    endtask

    task automatic setup(input int lo, input int hi, input string req);
        cfg_base  = AW'(lo);
        cfg_limit = AW'(hi);
        issue(2'd0, 2'd0, '0, req);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog: cycles=%0d expected below 20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check(tos_valid == 0 && depth == 0, "R10 empty after reset", depth, 0);
        check(busy == 0 && mem_req_valid == 0, "R10 idle after reset", busy, 0);
        check(fault_ovf == 0 && fault_unf == 0, "R10 no faults after reset", fault_ovf, 0);
        rst_n = 1'b1;

        // R10: reset bounds give capacity two
        push(16'h0a0a, "R10 cap push1");
        push(16'h0b0b, "R10 cap push2");
        push(16'h0c0c, "R10 cap push3 overflow");
        check(depth == 2, "R10 capacity two", depth, 2);

        // R8: window 11..13, capacity five
        lat = 0;
        setup(10, 13, "R8 setup");
        check(depth == 0 && tos_valid == 0, "R8 setup empties", depth, 0);
        push(16'h0011, "R1 push");
        push(16'h0022, "R1 push");
        push(16'h0033, "R2 spill");
        push(16'h0044, "R2 spill");
        push(16'h0055, "R2 spill");
        push(16'h0066, "R3 overflow");
        check(depth == 5 && tos_data == 16'h0055, "R3 state kept", tos_data, 16'h0055);

        // R5 and R4: drain with operations and refills
        alu(2'd1, "R5 subtract");
        alu(2'd2, "R5 and");
        alu(2'd3, "R5 or");
        pop("R4 pop");
        pop("R4 pop");
        check(depth == 0, "R4 drained", depth, 0);
        pop("R6 pop empty");
        alu(2'd0, "R6 alu empty");
        push(16'h1234, "R1 push single");
        alu(2'd0, "R6 alu single");
        check(tos_data == 16'h1234 && depth == 1, "R6 state kept", tos_data, 16'h1234);

        // R5: wrap-around with memory waits
        lat = 2;
        push(16'hffff, "R1 push");
        push(16'h0001, "R2 spill slow");
        alu(2'd0, "R5 add wrap");
        check(tos_data == 16'h0000, "R5 add wraps", tos_data, 0);
        alu(2'd1, "R5 subtract order");
        check(tos_data == 16'h1234, "R5 second minus top", tos_data, 16'h1234);

        // R7: command presented mid-spill is ignored
        lat = 3;
        push(16'h0aaa, "R1 push");
        push(16'h0bbb, "R2 spill");
        check(busy == 1, "R7 busy before ignored command", busy, 1);
        cmd_valid = 1'b1;
        cmd_kind  = 2'd1;
        cmd_data  = 16'hdead;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
        check(depth == 3 && tos_data == 16'h0bbb, "R7 ignored while busy", tos_data, 16'h0bbb);
        pop("R4 pop slow");
        pop("R4 pop slow");
        check(tos_data == 16'h1234, "R4 lifo order", tos_data, 16'h1234);

        // R8: setup on a populated stack
        lat = 1;
        push(16'h5a5a, "R1 push");
        push(16'ha5a5, "R2 spill");
        setup(40, 42, "R8 setup nonempty");
        check(depth == 0 && tos_valid == 0, "R8 cleared", depth, 0);
        push(16'h7777, "R1 push after setup");
        push(16'h8888, "R1 push");
        push(16'h9999, "R2 spill into new window");
        pop("R4 refill new window");
        pop("R4 pop");
        pop("R4 pop last");
        pop("R6 underflow");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule